// File: doc/BRIEF.md
# Grouped External Interrupt Request Generator

This block turns the levels of a group of port pins into one interrupt request line for the CPU. Each pin joins the group only when it is configured as an input with interrupt enabled. The levels of the pins that take part are combined with a logical AND into one group signal. A pin that is held low therefore keeps the group signal low and hides any activity on the other pins. When no pin takes part, the group signal rests high.

A two-bit sensitivity setting chooses which behaviour of the group signal sets an internal pending flag. The choices are low level (which also covers the falling edge), rising edge, falling edge, or either edge. Software cannot read or write the pending flag. It is cleared when the CPU acknowledges the vector fetch. Software can clear it only by writing a different sensitivity value. The request output is the pending flag, so it changes one clock edge after the cycle that caused the change.

Pin levels are expected to be synchronized to `clk` already. All ports are plain control signals. No data flows through the block, so it has no valid/ready handshake and never applies back-pressure.

Top module: `exti_group_irq`

## Requirements
- R1: Pin i takes part in the group only when `pin_dir[i]`=0 and `pin_opt[i]`=1. The level of any other pin has no effect on `irq_req`.
- R2: The group signal is the AND of the levels of the pins that take part. While any participating pin is low, activity on the other pins produces no edge.
- R3: When no pin takes part, the group signal is 1 and no request is raised in any sensitivity mode.
- R4: The sensitivity codes are as follows. 2'b00 raises a request in every cycle the group signal is low. 2'b01 raises one on a rising edge only. 2'b10 raises one on a falling edge only. 2'b11 raises one on either edge. An edge means the group signal differs from its value in the previous cycle.
- R5: A qualifying cycle sets `irq_req` at the next clock edge. The request then holds until it is cleared by R6 or R8.
- R6: `vec_ack` clears `irq_req` at the next edge if no qualifying event occurs in the same cycle.
- R7: When a qualifying event and `vec_ack` occur in the same cycle, `irq_req` stays 1.
- R8: A sensitivity write (`sens_wr_en`=1) whose data differs from the current setting clears `irq_req` at the next edge. This holds even if an event occurs in that cycle. The new setting applies from the following cycle.
- R9: A sensitivity write whose data equals the current setting has no effect.
- R10: After reset, `irq_req`=0, the sensitivity is 2'b00 and the previous group value is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | NUM_PINS | Synchronized pin levels |
| pin_dir | input | NUM_PINS | Direction bits, 1 = output |
| pin_opt | input | NUM_PINS | Option bits, 1 with input = interrupt enabled |
| sens_wr_en | input | 1 | Sensitivity write strobe |
| sens_wr_data | input | 2 | Sensitivity value to write |
| vec_ack | input | 1 | CPU vector-fetch acknowledge |
| irq_req | output | 1 | Interrupt request |

## Verification
A wrong pending flag shows on `irq_req` at the very next clock edge, because the output is that flag. A wrong stored previous group value or sensitivity setting shows up differently. It appears only when the next edge or level condition is evaluated against it. That can be many cycles later, so the stimulus toggles pins often and mixes sensitivity writes with acknowledges. A participation or masking fault appears when a pin's role changes while its level differs from the rest of the group.

// File: rtl/exti_pkg.sv
package exti_pkg;
  typedef enum logic [1:0] {
    SENS_LOW_FALL = 2'b00,
    SENS_RISE     = 2'b01,
    SENS_FALL     = 2'b10,
    SENS_BOTH     = 2'b11
  } exti_sens_e;
endpackage

// File: rtl/exti_group_combine.sv
module exti_group_combine #(
  parameter int NUM_PINS = 8
) (
  input  logic [NUM_PINS-1:0] pin_lvl,
  input  logic [NUM_PINS-1:0] pin_dir,
  input  logic [NUM_PINS-1:0] pin_opt,
  output logic                grp_sig
);
  logic [NUM_PINS-1:0] masked;

  // Pins that do not take part are forced to 1, the identity of AND.
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    always_comb masked[i] = pin_lvl[i] | pin_dir[i] | ~pin_opt[i];
  end

  always_comb grp_sig = &masked;
endmodule

// File: rtl/exti_sens_reg.sv
module exti_sens_reg
  import exti_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sens_wr_en,
  input  logic [1:0] sens_wr_data,
  output exti_sens_e sens_q,
  output logic       sens_clr
);
  exti_sens_e wr_val;

  always_comb begin
    wr_val   = exti_sens_e'(sens_wr_data);
    sens_clr = sens_wr_en && (wr_val != sens_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sens_q <= SENS_LOW_FALL;
    else if (sens_clr) sens_q <= wr_val;
  end
endmodule

// File: rtl/exti_event_detect.sv
module exti_event_detect
  import exti_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       grp_sig,
  input  exti_sens_e sens_q,
  output logic       grp_prev,
  output logic       evt
);
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grp_prev <= 1'b1;
    else        grp_prev <= grp_sig;
  end

  always_comb begin
    rise = grp_sig & ~grp_prev;
    fall = ~grp_sig & grp_prev;
    unique case (sens_q)
      SENS_LOW_FALL: evt = ~grp_sig;
      SENS_RISE:     evt = rise;
      SENS_FALL:     evt = fall;
      SENS_BOTH:     evt = rise | fall;
      default:       evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/exti_pending.sv
module exti_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic vec_ack,
  input  logic sens_clr,
  output logic pend_q
);
  // Priority: sensitivity change clear, then new event, then acknowledge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend_q <= 1'b0;
    else if (sens_clr) pend_q <= 1'b0;
    else if (evt)      pend_q <= 1'b1;
    else if (vec_ack)  pend_q <= 1'b0;
  end
endmodule

// File: rtl/exti_group_irq.sv
module exti_group_irq
  import exti_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_lvl,
  input  logic [NUM_PINS-1:0] pin_dir,
  input  logic [NUM_PINS-1:0] pin_opt,
  input  logic                sens_wr_en,
  input  logic [1:0]          sens_wr_data,
  input  logic                vec_ack,
  output logic                irq_req
);
  logic       grp_sig;
  logic       grp_prev;
  logic       evt;
  logic       sens_clr;
  exti_sens_e sens_q;

  exti_group_combine #(.NUM_PINS(NUM_PINS)) u_combine (
    .pin_lvl (pin_lvl),
    .pin_dir (pin_dir),
    .pin_opt (pin_opt),
    .grp_sig (grp_sig)
  );

  exti_sens_reg u_sens (
    .clk          (clk),
    .rst_n        (rst_n),
    .sens_wr_en   (sens_wr_en),
    .sens_wr_data (sens_wr_data),
    .sens_q       (sens_q),
    .sens_clr     (sens_clr)
  );

  exti_event_detect u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .grp_sig  (grp_sig),
    .sens_q   (sens_q),
    .grp_prev (grp_prev),
    .evt      (evt)
  );

  exti_pending u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt),
    .vec_ack  (vec_ack),
    .sens_clr (sens_clr),
    .pend_q   (irq_req)
  );
endmodule

// File: rtl/exti_group_irq_chk.sv
module exti_group_irq_chk #(
  parameter int NUM_PINS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] pin_lvl,
  input logic [NUM_PINS-1:0] pin_dir,
  input logic [NUM_PINS-1:0] pin_opt,
  input logic                sens_wr_en,
  input logic [1:0]          sens_wr_data,
  input logic                vec_ack,
  input logic                irq_req,
  input logic                grp_sig,
  input logic                grp_prev,
  input logic                evt,
  input logic [1:0]          sens_q
);
  logic [NUM_PINS-1:0] part;
  logic                wr_chg;
  always_comb begin
    part   = ~pin_dir & pin_opt;
    wr_chg = sens_wr_en && (sens_wr_data != sens_q);
  end

  a_r2_low_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (|(part & ~pin_lvl)) |-> !grp_sig);
  a_r3_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (part == '0) |-> grp_sig);
  a_r4_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && sens_q == 2'b01) |-> (grp_sig && !grp_prev));
  a_r4_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && sens_q == 2'b10) |-> (!grp_sig && grp_prev));
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !vec_ack && !wr_chg) |=> irq_req);
  a_r5_set: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !wr_chg && !vec_ack) |=> irq_req);
  a_r6_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_ack && !evt) |=> !irq_req);
  a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_ack && evt && !wr_chg) |=> irq_req);
  a_r8_sens_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr_chg |=> !irq_req);
  a_r9_same_write: assert property (@(posedge clk) disable iff (!rst_n)
    (sens_wr_en && !wr_chg) |=> $stable(sens_q));
endmodule

bind exti_group_irq exti_group_irq_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pin_lvl      (pin_lvl),
  .pin_dir      (pin_dir),
  .pin_opt      (pin_opt),
  .sens_wr_en   (sens_wr_en),
  .sens_wr_data (sens_wr_data),
  .vec_ack      (vec_ack),
  .irq_req      (irq_req),
  .grp_sig      (grp_sig),
  .grp_prev     (grp_prev),
  .evt          (evt),
  .sens_q       (sens_q)
);

// File: tb/exti_group_irq_bench.sv
module exti_group_irq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pin_lvl = '1, pin_dir = '0, pin_opt = '0;
  logic         sens_wr_en = 1'b0;
  logic [1:0]   sens_wr_data = 2'b00;
  logic         vec_ack = 1'b0;
  logic         irq_req;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic       m_gq, m_pend;
  logic [1:0] m_sens;

  exti_group_irq #(.NUM_PINS(N)) u_exti_group_irq (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .pin_dir(pin_dir),
    .pin_opt(pin_opt), .sens_wr_en(sens_wr_en), .sens_wr_data(sens_wr_data),
    .vec_ack(vec_ack), .irq_req(irq_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic f_group(logic [N-1:0] l, logic [N-1:0] d, logic [N-1:0] o);
    logic g = 1'b1;
    for (int i = 0; i < N; i++) if (!d[i] && o[i] && !l[i]) g = 1'b0;
    return g;
  endfunction

  function automatic logic f_event(logic [1:0] s, logic g, logic gq);
    case (s)
      2'b00:   return !g;
      2'b01:   return g && !gq;
      2'b10:   return !g && gq;
      default: return g != gq;
    endcase
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: irq_req=%0b expected %0b", tag, act, exp);
    end
  endtask

  // Inputs already driven at a negedge; advance one cycle and compare.
  task automatic cycle(string tag);
    logic g, e, chg, np;
    g   = f_group(pin_lvl, pin_dir, pin_opt);
    e   = f_event(m_sens, g, m_gq);
    chg = sens_wr_en && (sens_wr_data != m_sens);
    np  = chg ? 1'b0 : e ? 1'b1 : vec_ack ? 1'b0 : m_pend;
    @(posedge clk);
    m_pend = np;
    m_gq   = g;
    if (chg) m_sens = sens_wr_data;
    @(negedge clk);
    check(tag, irq_req, m_pend);
    sens_wr_en = 1'b0;
    vec_ack    = 1'b0;
  endtask

  task automatic wr_sens(logic [1:0] v, string tag);
    sens_wr_en = 1'b1; sens_wr_data = v;
    cycle(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    if (!done) begin
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5e_a7c3));
    m_gq = 1'b1; m_pend = 1'b0; m_sens = 2'b00;
    repeat (3) @(negedge clk);
    check("R10 reset", irq_req, 1'b0);
    rst_n = 1'b1;
    cycle("R10 after reset");

    // R3: nothing participates, pins low, level mode
    pin_lvl = '0; pin_dir = '0; pin_opt = '0;
    cycle("R3 idle"); cycle("R3 idle");
    // R1: outputs with option bit set do not take part
    pin_dir = '1; pin_opt = '1;
    cycle("R1 output ignored");
    pin_dir = '0; pin_opt = 8'h01; pin_lvl = 8'hFF;
    cycle("R1 input no int ignored");
    // R4 level mode: pin0 low raises, stays while low after ack (R7)
    pin_lvl = 8'hFE;
    cycle("R4 level set");
    vec_ack = 1'b1; cycle("R7 level persists over ack");
    pin_lvl = 8'hFF; cycle("R5 hold");
    vec_ack = 1'b1; cycle("R6 ack clears");
    // R4 rising mode, R10 prev=1 gives no spurious edge
    wr_sens(2'b01, "R8 write rise");
    pin_lvl = 8'h00; cycle("R4 rise ignores fall");
    pin_lvl = 8'hFF; cycle("R4 rise sets");
    wr_sens(2'b01, "R9 same write keeps");
    wr_sens(2'b10, "R8 change clears");
    // R2: pin0 held low masks pin1 activity
    pin_opt = 8'h03; pin_lvl = 8'hFE; cycle("R4 fall sets");
    vec_ack = 1'b1; cycle("R6 ack clears");
    pin_lvl = 8'hFC; cycle("R2 masked");
    pin_lvl = 8'hFE; cycle("R2 masked");
    // R4 both edges, R7 edge together with ack
    wr_sens(2'b11, "R8 write both");
    pin_lvl = 8'hFF; vec_ack = 1'b1; cycle("R7 edge with ack");
    pin_lvl = 8'hFD; sens_wr_en = 1'b1; sens_wr_data = 2'b00;
    cycle("R8 clear beats event");

    // random phase
    for (int k = 0; k < 4000; k++) begin
      string tag;
      for (int i = 0; i < N; i++) begin
        pin_dir[i] = ($urandom % 10) < 3;
        pin_opt[i] = ($urandom % 10) < 7;
        pin_lvl[i] = ($urandom % 10) < 8;
      end
      if (k % 3 != 0) begin pin_dir = u_hold_dir; pin_opt = u_hold_opt; end
      vec_ack      = ($urandom % 8) == 0;
      sens_wr_en   = ($urandom % 16) == 0;
      sens_wr_data = 2'($urandom);
      tag = sens_wr_en ? "R8/R9 random" : vec_ack ? "R6/R7 random" : "R4/R5 random";
      u_hold_dir = pin_dir; u_hold_opt = pin_opt;
      cycle(tag);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  logic [N-1:0] u_hold_dir = '0, u_hold_opt = '1;
endmodule